// File: doc/BRIEF.md
# Asynchronous Timer Register Update Bridge

This block connects a CPU running on a fast clock to an 8-bit timer that counts on a separate, slower clock. The CPU can write three timer registers: the counter value, the compare value and the control byte. Each of the three has its own holding register on the CPU side and its own busy flag. A write goes into the holding register and sets that flag. A toggle request then crosses into the timer domain, and the value is copied into the live register on the second rising edge of the timer clock that sees the request. The acknowledge toggle comes back through a two-flop synchronizer and clears the busy flag.

The timer domain contains the counter, the committed compare value and the committed control byte. While the control enable bit is set, the counter steps by one on every timer edge. Wrap and compare events travel back to the CPU domain as toggles and set sticky flags there. The CPU clears those flags by writing ones. A write to a register whose busy flag is still set is dropped, and a sticky error bit is raised. Compare detection is suppressed on any timer edge at which a counter or compare update is in flight in the timer domain. The CPU clock must run at more than four times the timer clock.

Top module: `asyncTimerBridge`

## Requirements
- R1: After reset the live counter, the compare and control holding registers and the status word all read 0.
- R2: A CPU write with wrSel 0 (counter), 1 (compare) or 2 (control) loads that holding register. In the next CPU cycle it sets that register's busy bit in the status word (bit 0 counter, bit 1 compare, bit 2 control).
- R3: A written value reaches its timer-domain register on the second timer-clock rising edge after the write. The busy bit stays set until after that edge and clears within four CPU cycles of it.
- R4: The three channels are independent: writing one register while another is busy is accepted, and both values commit.
- R5: rdSel 0 returns the live counter. rdSel 1 and 2 return the compare and control holding registers. rdSel 3 returns the status word {2'b0, error (bit 5), compare flag (bit 4), overflow flag (bit 3), busy[2:0]}.
- R6: A write to a register whose busy bit is set leaves its holding register unchanged and sets status bit 5. Writing wrSel 3 with data bit 5 set clears it.
- R7: While control bit 0 is set in the timer domain, the counter advances by one on every timer edge. While it is clear, the counter holds its value. A counter commit overrides both.
- R8: A timer edge at which an enabled counter reads 255 takes it to 0 and sets status bit 3. Writing wrSel 3 with data bit 3 set clears it.
- R9: A timer edge at which an enabled counter equals the committed compare value sets status bit 4. Writing wrSel 3 with data bit 4 set clears it.
- R10: No compare event is raised on a timer edge at which a counter or compare update has been seen by the timer domain but not yet committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuClk | input | 1 | Fast CPU-side clock |
| tmrClk | input | 1 | Slow asynchronous timer clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| wrSel | input | 2 | Write target: 0 counter, 1 compare, 2 control, 3 flag clear |
| wrData | input | 8 | CPU write data |
| rdSel | input | 2 | Read source: 0 live counter, 1 compare hold, 2 control hold, 3 status |
| rdData | output | 8 | Combinational read data |

## Verification
The hardest case to reach is the suppressed compare. A compare update has to be in flight at the exact timer edge where the running counter equals the old compare value. The bench lines up on a timer edge and reads the live counter. It then waits the computed number of edges until the counter sits one below the old compare value, and writes a new compare value straight away. This puts the commit edge on the matching count. The compare flag must then stay clear, while a separate pass with no write in flight shows that the same count does raise it.

// File: rtl/atbPkg.sv
package atbPkg;

  localparam int NumChan  = 3;
  localparam int CtlEnBit = 0;

  // status word bit positions
  localparam int StOvfBit = 3;
  localparam int StCmpBit = 4;
  localparam int StErrBit = 5;

  typedef enum logic [1:0] {
    SEL_CNT = 2'd0,
    SEL_CMP = 2'd1,
    SEL_CTL = 2'd2,
    SEL_FLG = 2'd3
  } regSel_e;

  // CPU domain -> timer domain strobes
  typedef struct packed {
    logic [NumChan-1:0] reqTgl;
  } cpuStrobes_t;

  // timer domain -> CPU domain strobes
  typedef struct packed {
    logic [NumChan-1:0] ackTgl;
    logic               ovfTgl;
    logic               cmpTgl;
  } tmrStrobes_t;

endpackage

// File: rtl/atbSync.sv
module atbSync #(
  parameter int Width  = 1,
  parameter int Stages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] d,
  output logic [Width-1:0] q
);

  logic [Width-1:0] chain [Stages];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < Stages; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < Stages; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[Stages-1];

endmodule

// File: rtl/atbCtrl.sv
module atbCtrl
  import atbPkg::*;
#(
  parameter int DataW     = 8,
  parameter int AckStages = 2
) (
  input  logic                       cpuClk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [1:0]                 wrSel,
  input  logic [DataW-1:0]           wrData,
  input  tmrStrobes_t                tmrStb,
  output cpuStrobes_t                cpuStb,
  output logic [NumChan-1:0][DataW-1:0] hold,
  output logic [NumChan-1:0]         busy,
  output logic                       ovfFlag,
  output logic                       cmpFlag,
  output logic                       wrErr
);

  regSel_e            selE;
  logic [NumChan:0]   busyExt;
  logic               tgtBusy;
  logic               isReg;
  logic               rejectWr;
  logic               clrWr;
  logic [NumChan-1:0] ackSync;
  logic [1:0]         evtSync;
  logic [1:0]         evtPrev;
  logic               ovfEvt;
  logic               cmpEvt;

  assign selE     = regSel_e'(wrSel);
  assign busyExt  = {1'b0, busy};
  assign tgtBusy  = busyExt[wrSel];
  assign isReg    = (selE != SEL_FLG);
  assign rejectWr = wrEn && isReg && tgtBusy;
  assign clrWr    = wrEn && !isReg;

  // acknowledge toggles back from the timer domain
  atbSync #(.Width(NumChan), .Stages(AckStages)) u_ackSync (
    .clk  (cpuClk),
    .rstN (rstN),
    .d    (tmrStb.ackTgl),
    .q    (ackSync)
  );

  // per-channel holding register and request toggle
  for (genvar ch = 0; ch < NumChan; ch++) begin : g_chan
    logic [DataW-1:0] holdR;
    logic             tglR;
    logic             acceptWr;

    assign acceptWr = wrEn && (wrSel == 2'(ch)) && !busy[ch];

    always_ff @(posedge cpuClk or negedge rstN) begin
      if (!rstN) begin
        holdR <= '0;
        tglR  <= 1'b0;
      end else if (acceptWr) begin
        holdR <= wrData;
        tglR  <= ~tglR;
      end
    end

    assign hold[ch]          = holdR;
    assign cpuStb.reqTgl[ch] = tglR;
    assign busy[ch]          = tglR ^ ackSync[ch];
  end

  // event toggles from the timer domain
  atbSync #(.Width(2), .Stages(2)) u_evtSync (
    .clk  (cpuClk),
    .rstN (rstN),
    .d    ({tmrStb.ovfTgl, tmrStb.cmpTgl}),
    .q    (evtSync)
  );

  always_ff @(posedge cpuClk or negedge rstN) begin
    if (!rstN) evtPrev <= '0;
    else       evtPrev <= evtSync;
  end

  assign ovfEvt = evtSync[1] ^ evtPrev[1];
  assign cmpEvt = evtSync[0] ^ evtPrev[0];

  // sticky flags: a set in the same cycle as a clear wins
  always_ff @(posedge cpuClk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      cmpFlag <= 1'b0;
      wrErr   <= 1'b0;
    end else begin
      if (ovfEvt)                            ovfFlag <= 1'b1;
      else if (clrWr && wrData[StOvfBit])    ovfFlag <= 1'b0;
      if (cmpEvt)                            cmpFlag <= 1'b1;
      else if (clrWr && wrData[StCmpBit])    cmpFlag <= 1'b0;
      if (rejectWr)                          wrErr   <= 1'b1;
      else if (clrWr && wrData[StErrBit])    wrErr   <= 1'b0;
    end
  end

endmodule

// File: rtl/atbDatapath.sv
module atbDatapath
  import atbPkg::*;
#(
  parameter int DataW       = 8,
  parameter int CommitEdges = 2
) (
  input  logic                          tmrClk,
  input  logic                          rstN,
  input  cpuStrobes_t                   cpuStb,
  input  logic [NumChan-1:0][DataW-1:0] hold,
  output tmrStrobes_t                   tmrStb,
  output logic [DataW-1:0]              cntQ,
  output logic [DataW-1:0]              cmpQ,
  output logic [DataW-1:0]              ctlQ,
  output logic [NumChan-1:0]            commit
);

  localparam int SeenStages = CommitEdges - 1;
  localparam int IdxCnt     = int'(SEL_CNT);
  localparam int IdxCmp     = int'(SEL_CMP);
  localparam int IdxCtl     = int'(SEL_CTL);

  logic [NumChan-1:0] reqSeen;
  logic [NumChan-1:0] reqDone;
  logic               cntEn;
  logic               cmpBlock;
  logic               wrapNow;
  logic               matchNow;
  logic               ovfTglR;
  logic               cmpTglR;

  atbSync #(.Width(NumChan), .Stages(SeenStages)) u_reqSync (
    .clk  (tmrClk),
    .rstN (rstN),
    .d    (cpuStb.reqTgl),
    .q    (reqSeen)
  );

  // a request is pending from the edge that sees it until the commit edge
  assign commit = reqSeen ^ reqDone;

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) reqDone <= '0;
    else       reqDone <= reqSeen;
  end

  assign cntEn    = ctlQ[CtlEnBit];
  assign cmpBlock = commit[IdxCnt] || commit[IdxCmp];
  assign wrapNow  = cntEn && !commit[IdxCnt] && (cntQ == '1);
  assign matchNow = cntEn && !cmpBlock && (cntQ == cmpQ);

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (commit[IdxCnt]) begin
      cntQ <= hold[IdxCnt];
    end else if (cntEn) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) begin
      cmpQ <= '0;
      ctlQ <= '0;
    end else begin
      if (commit[IdxCmp]) cmpQ <= hold[IdxCmp];
      if (commit[IdxCtl]) ctlQ <= hold[IdxCtl];
    end
  end

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) begin
      ovfTglR <= 1'b0;
      cmpTglR <= 1'b0;
    end else begin
      if (wrapNow)  ovfTglR <= ~ovfTglR;
      if (matchNow) cmpTglR <= ~cmpTglR;
    end
  end

  assign tmrStb.ackTgl = reqDone;
  assign tmrStb.ovfTgl = ovfTglR;
  assign tmrStb.cmpTgl = cmpTglR;

endmodule

// File: rtl/asyncTimerBridge.sv
module asyncTimerBridge
  import atbPkg::*;
#(
  parameter int DataW       = 8,
  parameter int CommitEdges = 2,
  parameter int AckStages   = 2
) (
  input  logic             cpuClk,
  input  logic             tmrClk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [DataW-1:0] wrData,
  input  logic [1:0]       rdSel,
  output logic [DataW-1:0] rdData
);

  cpuStrobes_t                   cpuStb;
  tmrStrobes_t                   tmrStb;
  logic [NumChan-1:0][DataW-1:0] hold;
  logic [NumChan-1:0]            busy;
  logic                          ovfFlag;
  logic                          cmpFlag;
  logic                          wrErr;
  logic [DataW-1:0]              cntQ;
  logic [DataW-1:0]              cmpQ;
  logic [DataW-1:0]              ctlQ;
  logic [NumChan-1:0]            commit;
  logic [DataW-1:0]              status;

  atbCtrl #(.DataW(DataW), .AckStages(AckStages)) u_ctrl (
    .cpuClk  (cpuClk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .tmrStb  (tmrStb),
    .cpuStb  (cpuStb),
    .hold    (hold),
    .busy    (busy),
    .ovfFlag (ovfFlag),
    .cmpFlag (cmpFlag),
    .wrErr   (wrErr)
  );

  atbDatapath #(.DataW(DataW), .CommitEdges(CommitEdges)) u_dp (
    .tmrClk (tmrClk),
    .rstN   (rstN),
    .cpuStb (cpuStb),
    .hold   (hold),
    .tmrStb (tmrStb),
    .cntQ   (cntQ),
    .cmpQ   (cmpQ),
    .ctlQ   (ctlQ),
    .commit (commit)
  );

  assign status = DataW'({wrErr, cmpFlag, ovfFlag, busy});

  always_comb begin
    unique case (regSel_e'(rdSel))
      SEL_CNT: rdData = cntQ;
      SEL_CMP: rdData = hold[int'(SEL_CMP)];
      SEL_CTL: rdData = hold[int'(SEL_CTL)];
      default: rdData = status;
    endcase
  end

endmodule

// File: rtl/atbChecker.sv
module atbChecker #(
  parameter int DataW = 8
) (
  input logic             cpuClk,
  input logic             tmrClk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrSel,
  input logic [2:0]       busy,
  input logic             wrErr,
  input logic [DataW-1:0] cntQ,
  input logic [DataW-1:0] ctlQ,
  input logic [2:0]       commit,
  input logic             ovfTgl,
  input logic             cmpTgl
);

  logic [3:0] busyExt;
  assign busyExt = {1'b0, busy};

  // R2
  busy_set_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    (wrEn && wrSel != 2'd3 && !busyExt[wrSel]) |=> busyExt[$past(wrSel)]);

  // R6
  busy_write_err_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    (wrEn && wrSel != 2'd3 && busyExt[wrSel]) |=> wrErr);

  // R7
  count_step_chk: assert property (@(posedge tmrClk) disable iff (!rstN)
    (ctlQ[0] && !commit[0]) |=> (cntQ == DataW'($past(cntQ) + 1'b1)));

  // R7
  count_hold_chk: assert property (@(posedge tmrClk) disable iff (!rstN)
    (!ctlQ[0] && !commit[0]) |=> $stable(cntQ));

  // R8
  wrap_event_chk: assert property (@(posedge tmrClk) disable iff (!rstN)
    (ctlQ[0] && !commit[0] && cntQ == '1) |=> (ovfTgl != $past(ovfTgl)));

  // R10
  cmp_block_chk: assert property (@(posedge tmrClk) disable iff (!rstN)
    (commit[0] || commit[1]) |=> $stable(cmpTgl));

endmodule

bind asyncTimerBridge atbChecker #(.DataW(DataW)) u_atbChk (
  .cpuClk (cpuClk),
  .tmrClk (tmrClk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrSel  (wrSel),
  .busy   (busy),
  .wrErr  (wrErr),
  .cntQ   (cntQ),
  .ctlQ   (ctlQ),
  .commit (commit),
  .ovfTgl (tmrStb.ovfTgl),
  .cmpTgl (tmrStb.cmpTgl)
);

// File: tb/test_asyncTimerBridge.sv
`timescale 1ns/1ps
module test_asyncTimerBridge;

  logic       cpuClk = 1'b0;
  logic       tmrClk = 1'b0;
  logic       rstN   = 1'b0;
  logic       wrEn   = 1'b0;
  logic [1:0] wrSel  = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [1:0] rdSel  = 2'd0;
  logic [7:0] rdData;

  int  vecCount = 0;
  int  errCount = 0;
  bit  finished = 1'b0;

  asyncTimerBridge i_asyncTimerBridge (
    .cpuClk (cpuClk),
    .tmrClk (tmrClk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .rdSel  (rdSel),
    .rdData (rdData)
  );

  always #4 cpuClk = ~cpuClk;          // 125 MHz
  initial begin
    #3;
    forever #40 tmrClk = ~tmrClk;      // 12.5 MHz, rising edges off the CPU grid
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vecCount++;
    if (got !== exp) begin
      errCount++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] val);
    rdSel = sel;
    #1;
    val = rdData;
  endtask

  // called at a CPU falling edge, returns at a CPU falling edge
  task automatic cpuWrite(input logic [1:0] sel, input logic [7:0] data);
    wrEn   = 1'b1;
    wrSel  = sel;
    wrData = data;
    @(negedge cpuClk);
    wrEn   = 1'b0;
  endtask

  task automatic syncTmr();
    @(posedge tmrClk);
    @(negedge cpuClk);
  endtask

  task automatic waitTmr(input int n);
    repeat (n) @(posedge tmrClk);
    @(negedge cpuClk);
  endtask

  task automatic waitCpu(input int n);
    repeat (n) @(negedge cpuClk);
  endtask

  task automatic expectReg(input string tag, input logic [1:0] sel, input logic [7:0] exp);
    logic [7:0] v;
    readReg(sel, v);
    check(tag, v, exp);
  endtask

  initial begin
    #500us;
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] held;
    int         gap;

    #21;
    rstN = 1'b1;
    waitCpu(2);

    // R1 reset state
    expectReg("R1 counter", 2'd0, 8'h00);
    expectReg("R1 cmp hold", 2'd1, 8'h00);
    expectReg("R1 ctl hold", 2'd2, 8'h00);
    expectReg("R1 status", 2'd3, 8'h00);

    // R2 / R3 counter write and commit timing
    syncTmr();
    cpuWrite(2'd0, 8'h55);
    expectReg("R2 status busy bit0", 2'd3, 8'h01);
    expectReg("R2 live counter untouched", 2'd0, 8'h00);
    waitTmr(1);
    expectReg("R3 not yet committed", 2'd0, 8'h00);
    expectReg("R3 busy held", 2'd3, 8'h01);
    waitTmr(1);
    expectReg("R3 committed on second edge", 2'd0, 8'h55);
    waitCpu(4);
    expectReg("R3 busy cleared", 2'd3, 8'h00);

    // R6 write while busy is dropped
    syncTmr();
    cpuWrite(2'd1, 8'h10);
    cpuWrite(2'd1, 8'h99);
    expectReg("R6 hold unchanged", 2'd1, 8'h10);
    expectReg("R6 error set", 2'd3, 8'h22);
    cpuWrite(2'd3, 8'h20);
    expectReg("R6 error cleared", 2'd3, 8'h02);
    waitTmr(3);
    waitCpu(4);
    expectReg("R6 busy done", 2'd3, 8'h00);

    // R5 sweep of compare holding read-back
    for (int k = 0; k < 8; k++) begin
      syncTmr();
      cpuWrite(2'd1, 8'(k * 37 + 5));
      expectReg("R5 cmp hold readback", 2'd1, 8'(k * 37 + 5));
      waitTmr(2);
      waitCpu(4);
      expectReg("R5 status after commit", 2'd3, 8'h00);
    end

    // R4 two channels in flight together
    syncTmr();
    cpuWrite(2'd0, 8'h20);
    cpuWrite(2'd1, 8'h30);
    expectReg("R4 both busy", 2'd3, 8'h03);
    waitTmr(1);
    expectReg("R4 counter still old", 2'd0, 8'h55);
    waitTmr(1);
    expectReg("R4 counter committed", 2'd0, 8'h20);
    waitCpu(4);
    expectReg("R4 both idle", 2'd3, 8'h00);
    expectReg("R4 cmp hold kept", 2'd1, 8'h30);

    // R7 enable the counter
    syncTmr();
    cpuWrite(2'd2, 8'h01);
    expectReg("R2 ctl busy bit2", 2'd3, 8'h04);
    expectReg("R5 ctl hold", 2'd2, 8'h01);
    waitTmr(2);
    expectReg("R7 no step on enable commit", 2'd0, 8'h20);
    waitTmr(5);
    expectReg("R7 five steps", 2'd0, 8'h25);

    // R9 compare match at 0x30
    waitTmr(11);
    expectReg("R9 counter at compare", 2'd0, 8'h30);
    expectReg("R9 flag not yet", 2'd3, 8'h00);
    waitTmr(1);
    expectReg("R9 counter past compare", 2'd0, 8'h31);
    waitCpu(5);
    expectReg("R9 flag set", 2'd3, 8'h10);
    cpuWrite(2'd3, 8'h10);
    expectReg("R9 flag cleared", 2'd3, 8'h00);

    // R8 wrap
    syncTmr();
    cpuWrite(2'd0, 8'hFD);
    waitTmr(2);
    expectReg("R8 loaded", 2'd0, 8'hFD);
    waitTmr(2);
    expectReg("R8 at top", 2'd0, 8'hFF);
    expectReg("R8 no flag yet", 2'd3, 8'h00);
    waitTmr(1);
    expectReg("R8 wrapped", 2'd0, 8'h00);
    waitCpu(5);
    expectReg("R8 flag set", 2'd3, 8'h08);
    cpuWrite(2'd3, 8'h08);
    expectReg("R8 flag cleared", 2'd3, 8'h00);

    // R10 compare update in flight at the matching count
    syncTmr();
    readReg(2'd0, v);
    gap = int'(8'(8'h2F - v));
    if (gap > 0) waitTmr(gap);
    expectReg("R7 counter lined up", 2'd0, 8'h2F);
    cpuWrite(2'd1, 8'h80);
    waitTmr(1);
    expectReg("R10 counter at old compare", 2'd0, 8'h30);
    waitTmr(1);
    expectReg("R10 counter advanced", 2'd0, 8'h31);
    waitCpu(5);
    expectReg("R10 no compare flag", 2'd3, 8'h00);

    // R7 disable holds the counter
    syncTmr();
    cpuWrite(2'd2, 8'h00);
    waitTmr(2);
    readReg(2'd0, held);
    waitTmr(3);
    expectReg("R7 counter holds", 2'd0, held);
    expectReg("R7 status idle", 2'd3, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule